// File: doc/BRIEF.md
# Clock Root Configuration Register Controller

This block is the software-facing register set of one clock root generator. Software writes a source selection, a counter mode, a pre-divider value and three fractional-divider words (M, N, D) over a simple single-cycle write bus. Reads are combinational. These writes land in shadow copies only. The divider datapath and the glitch-free source multiplexer sit outside this block, and they see only the active copies.

To apply new settings, software writes the command word with its update bit set. One cycle later every shadow value moves into the active set in a single step. The update bit then stays set for a fixed synchronisation window and clears by itself, so a polling loop ends within a known bound. The command word also shows one dirty flag per shadow register, a root-enable request, and a read-only root-off status. The root-off status follows the datapath's running indication, the enable request and an external enable input.

Top module: `clkroot_cfg_ctrl`

## Requirements
- R1: After reset every shadow and active value is zero, the command word reads 0x8000_0000 while `root_on_i` and `ext_en_i` are low, and the active outputs are all zero.
- R2: A write to a shadow register reads back at once at its word address. The addresses are 0x04 config, 0x08 M, 0x0C N and 0x10 D. M, N and D occupy the low MND_W bits. The active outputs do not change until an update commits.
- R3: A command write with bit 0 set makes bit 0 read 1 from the next cycle. At the following clock edge all four shadow registers are copied into the active outputs together.
- R4: Bit 0 reads 1 for exactly SYNC_CYC+1 cycles after the write that set it, and then reads 0.
- R5: A command write with bit 0 set while an update is pending neither restarts nor extends the window. A command write with bit 0 clear does not cancel a pending update.
- R6: The command dirty flags sit at bit 4 (config), bit 5 (N), bit 6 (M) and bit 7 (D). A flag sets when its shadow register is written with a value that differs from the active one. A write equal to the active value leaves the flag clear.
- R7: A commit clears all dirty flags. A shadow write in the commit cycle is compared with the newly committed value and sets the flag only if it differs from that value.
- R8: Command bit 1 is a root-enable request that reads back as written. `root_en_o` is high while this request or `ext_en_i` is set.
- R9: Command bit 31 reads 1 only while `root_on_i`, the enable request and `ext_en_i` are all low.
- R10: Config fields sit at [10:8] source, [13:12] mode and [PREDIV_W-1:0] pre-divider, and the other config bits are dropped. Writes to command bits 31 and 7:4 have no effect. Unmapped or misaligned addresses read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| root_on_i | input | 1 | Datapath reports the root is running |
| ext_en_i | input | 1 | External enable vote for the root |
| root_en_o | output | 1 | Enable request to the datapath |
| act_src_o | output | 3 | Active source selection |
| act_mode_o | output | 2 | Active counter mode |
| act_prediv_o | output | PREDIV_W | Active pre-divider value |
| act_m_o | output | MND_W | Active M word |
| act_n_o | output | MND_W | Active N word |
| act_d_o | output | MND_W | Active D word |

## Verification
The commit edge and a shadow write can fall on the same clock edge. In that case the dirty decision must compare the write against the value that is being committed at that edge, not against the stale active value. The bench provokes this by issuing a config write on the cycle right after the update command. It does this once with a value that differs from the committed one, so the flag must be set, and once with the same value, so the flag must stay clear. A second overlap is a repeated update request inside the pending window. It is judged by sampling bit 0 on each cycle of the window and on the cycle just after it.

// File: rtl/clkroot_cfg_pkg.sv
package clkroot_cfg_pkg;

  localparam int SRC_W  = 3;
  localparam int MODE_W = 2;

  // command word bit positions (software polls these)
  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_EN_BIT    = 1;
  localparam int CMD_DIRTY_LSB = 4;
  localparam int CMD_OFF_BIT   = 31;

  // config field positions (decoded by the datapath driver code)
  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;

  // index of each fractional word inside the packed M/N/D arrays
  localparam int IDX_M = 0;
  localparam int IDX_N = 1;
  localparam int IDX_D = 2;
  localparam int NUM_FRAC = 3;

  typedef enum logic [2:0] {
    SEL_CMD = 3'd0,
    SEL_CFG = 3'd1,
    SEL_M   = 3'd2,
    SEL_N   = 3'd3,
    SEL_D   = 3'd4
  } reg_sel_e;

  function automatic logic [31:0] pack_cmd(input logic off, input logic d_dirty,
                                           input logic m_dirty, input logic n_dirty,
                                           input logic c_dirty, input logic en,
                                           input logic pend);
    logic [31:0] w;
    w = '0;
    w[CMD_OFF_BIT]       = off;
    w[CMD_DIRTY_LSB + 3] = d_dirty;
    w[CMD_DIRTY_LSB + 2] = m_dirty;
    w[CMD_DIRTY_LSB + 1] = n_dirty;
    w[CMD_DIRTY_LSB]     = c_dirty;
    w[CMD_EN_BIT]        = en;
    w[CMD_UPD_BIT]       = pend;
    return w;
  endfunction

  function automatic logic [31:0] pack_cfg(input logic [7:0] pre,
                                           input logic [SRC_W-1:0] src,
                                           input logic [MODE_W-1:0] mode);
    logic [31:0] w;
    w = '0;
    w[7:0] = pre;
    w[CFG_SRC_LSB +: SRC_W]   = src;
    w[CFG_MODE_LSB +: MODE_W] = mode;
    return w;
  endfunction

endpackage

// File: rtl/ccr_update_seq.sv
module ccr_update_seq #(
  parameter int SYNC_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pend_o,
  output logic commit_o
);
  localparam int CNT_W = (SYNC_CYC < 1) ? 1 : $clog2(SYNC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYC);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             win_done;

  assign commit_o = pend_q && (cnt_q == '0);
  assign win_done = pend_q && (cnt_q == CNT_LAST);
  assign pend_o   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!pend_q) begin
      if (start_i) begin
        pend_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (win_done) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q <= CNT_LAST)); // R4
  AST_WINDOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !pend_q); // R4
  AST_PEND_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(start_i)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !win_done && start_i) |=> (pend_q && cnt_q == $past(cnt_q) + CNT_W'(1))); // R5

endmodule

// File: rtl/ccr_shadow_bank.sv
module ccr_shadow_bank
  import clkroot_cfg_pkg::*;
#(
  parameter int CFG_W = 10,
  parameter int MND_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic                              wr_cfg_i,
  input  logic [CFG_W-1:0]                  cfg_new_i,
  input  logic [NUM_FRAC-1:0]               wr_frac_i,
  input  logic [MND_W-1:0]                  frac_new_i,
  input  logic [CFG_W-1:0]                  act_cfg_i,
  input  logic [NUM_FRAC-1:0][MND_W-1:0]    act_frac_i,
  output logic [CFG_W-1:0]                  sh_cfg_o,
  output logic [NUM_FRAC-1:0][MND_W-1:0]    sh_frac_o,
  output logic                              dirty_cfg_o,
  output logic [NUM_FRAC-1:0]               dirty_frac_o
);

  logic [CFG_W-1:0] sh_cfg_q;
  logic             dirty_cfg_q;
  logic [CFG_W-1:0] cfg_ref;
  logic             cfg_differs;

  // on the commit edge the active value becomes today's shadow value
  assign cfg_ref     = commit_i ? sh_cfg_q : act_cfg_i;
  assign cfg_differs = wr_cfg_i && (cfg_new_i != cfg_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cfg_q    <= '0;
      dirty_cfg_q <= 1'b0;
    end else begin
      if (wr_cfg_i) sh_cfg_q <= cfg_new_i;
      dirty_cfg_q <= (dirty_cfg_q && !commit_i) || cfg_differs;
    end
  end

  assign sh_cfg_o    = sh_cfg_q;
  assign dirty_cfg_o = dirty_cfg_q;

  AST_CFG_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !wr_cfg_i) |=> !dirty_cfg_q); // R7
  AST_CFG_SAME_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!dirty_cfg_q && !commit_i && wr_cfg_i && cfg_new_i == act_cfg_i) |=> !dirty_cfg_q); // R6

  for (genvar gi = 0; gi < NUM_FRAC; gi++) begin : g_frac
    logic [MND_W-1:0] sh_q;
    logic             dirty_q;
    logic [MND_W-1:0] ref_val;
    logic             differs;

    assign ref_val = commit_i ? sh_q : act_frac_i[gi];
    assign differs = wr_frac_i[gi] && (frac_new_i != ref_val);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q    <= '0;
        dirty_q <= 1'b0;
      end else begin
        if (wr_frac_i[gi]) sh_q <= frac_new_i;
        dirty_q <= (dirty_q && !commit_i) || differs;
      end
    end

    assign sh_frac_o[gi]    = sh_q;
    assign dirty_frac_o[gi] = dirty_q;

    AST_FRAC_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !wr_frac_i[gi]) |=> !dirty_q); // R7
    AST_FRAC_DIFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_i && wr_frac_i[gi] && frac_new_i != act_frac_i[gi]) |=> dirty_q); // R6
  end

endmodule

// File: rtl/ccr_active_bank.sv
module ccr_active_bank
  import clkroot_cfg_pkg::*;
#(
  parameter int CFG_W = 10,
  parameter int MND_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit_i,
  input  logic [CFG_W-1:0]               sh_cfg_i,
  input  logic [NUM_FRAC-1:0][MND_W-1:0] sh_frac_i,
  output logic [CFG_W-1:0]               act_cfg_o,
  output logic [NUM_FRAC-1:0][MND_W-1:0] act_frac_o
);

  logic [CFG_W-1:0]               act_cfg_q;
  logic [NUM_FRAC-1:0][MND_W-1:0] act_frac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cfg_q  <= '0;
      act_frac_q <= '0;
    end else if (commit_i) begin
      act_cfg_q  <= sh_cfg_i;
      act_frac_q <= sh_frac_i;
    end
  end

  assign act_cfg_o  = act_cfg_q;
  assign act_frac_o = act_frac_q;

  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (act_cfg_q == $past(sh_cfg_i) && act_frac_q == $past(sh_frac_i))); // R3
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(act_cfg_q) && $stable(act_frac_q))); // R2

endmodule

// File: rtl/clkroot_cfg_ctrl.sv
module clkroot_cfg_ctrl
  import clkroot_cfg_pkg::*;
#(
  parameter int PREDIV_W = 5,
  parameter int MND_W    = 8,
  parameter int SYNC_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [4:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                root_on_i,
  input  logic                ext_en_i,
  output logic                root_en_o,
  output logic [2:0]          act_src_o,
  output logic [1:0]          act_mode_o,
  output logic [PREDIV_W-1:0] act_prediv_o,
  output logic [MND_W-1:0]    act_m_o,
  output logic [MND_W-1:0]    act_n_o,
  output logic [MND_W-1:0]    act_d_o
);
  localparam int CFG_W = SRC_W + MODE_W + PREDIV_W;

  // decode
  reg_sel_e sel;
  logic     aligned;
  logic     wr_cmd, wr_cfg;
  logic [NUM_FRAC-1:0] wr_frac;
  logic     upd_start;

  assign sel     = reg_sel_e'(bus_addr[4:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_comb begin
    wr_cmd  = 1'b0;
    wr_cfg  = 1'b0;
    wr_frac = '0;
    if (bus_wr && aligned) begin
      unique case (sel)
        SEL_CMD: wr_cmd          = 1'b1;
        SEL_CFG: wr_cfg          = 1'b1;
        SEL_M:   wr_frac[IDX_M]  = 1'b1;
        SEL_N:   wr_frac[IDX_N]  = 1'b1;
        SEL_D:   wr_frac[IDX_D]  = 1'b1;
        default: ;
      endcase
    end
  end

  assign upd_start = wr_cmd && bus_wdata[CMD_UPD_BIT];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // config packed as {src, mode, prediv}
  logic [CFG_W-1:0] cfg_new;
  assign cfg_new = {bus_wdata[CFG_SRC_LSB +: SRC_W],
                    bus_wdata[CFG_MODE_LSB +: MODE_W],
                    bus_wdata[PREDIV_W-1:0]};

  // enable request
  logic en_req_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      en_req_q <= 1'b0;
    else if (wr_cmd) en_req_q <= bus_wdata[CMD_EN_BIT];
  end

  // update handshake
  logic pend, commit;
  ccr_update_seq #(.SYNC_CYC(SYNC_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (upd_start),
    .pend_o   (pend),
    .commit_o (commit)
  );

  // shadow and active copies
  logic [CFG_W-1:0]               sh_cfg, act_cfg;
  logic [NUM_FRAC-1:0][MND_W-1:0] sh_frac, act_frac;
  logic                           dirty_cfg;
  logic [NUM_FRAC-1:0]            dirty_frac;

  ccr_shadow_bank #(.CFG_W(CFG_W), .MND_W(MND_W)) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_i     (commit),
    .wr_cfg_i     (wr_cfg),
    .cfg_new_i    (cfg_new),
    .wr_frac_i    (wr_frac),
    .frac_new_i   (bus_wdata[MND_W-1:0]),
    .act_cfg_i    (act_cfg),
    .act_frac_i   (act_frac),
    .sh_cfg_o     (sh_cfg),
    .sh_frac_o    (sh_frac),
    .dirty_cfg_o  (dirty_cfg),
    .dirty_frac_o (dirty_frac)
  );

  ccr_active_bank #(.CFG_W(CFG_W), .MND_W(MND_W)) u_active (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit),
    .sh_cfg_i   (sh_cfg),
    .sh_frac_i  (sh_frac),
    .act_cfg_o  (act_cfg),
    .act_frac_o (act_frac)
  );

  // status
  logic root_off;
  assign root_en_o = en_req_q || ext_en_i;
  assign root_off  = !(root_on_i || root_en_o);

  // read path
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (sel)
        SEL_CMD: bus_rdata = pack_cmd(root_off, dirty_frac[IDX_D], dirty_frac[IDX_M],
                                      dirty_frac[IDX_N], dirty_cfg, en_req_q, pend);
        SEL_CFG: bus_rdata = pack_cfg(8'(sh_cfg[PREDIV_W-1:0]),
                                      sh_cfg[CFG_W-1 -: SRC_W],
                                      sh_cfg[PREDIV_W +: MODE_W]);
        SEL_M:   bus_rdata = 32'(sh_frac[IDX_M]);
        SEL_N:   bus_rdata = 32'(sh_frac[IDX_N]);
        SEL_D:   bus_rdata = 32'(sh_frac[IDX_D]);
        default: bus_rdata = '0;
      endcase
    end
  end

  // active outputs
  assign act_src_o    = act_cfg[CFG_W-1 -: SRC_W];
  assign act_mode_o   = act_cfg[PREDIV_W +: MODE_W];
  assign act_prediv_o = act_cfg[PREDIV_W-1:0];
  assign act_m_o      = act_frac[IDX_M];
  assign act_n_o      = act_frac[IDX_N];
  assign act_d_o      = act_frac[IDX_D];

  AST_EN_REQ_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bus_wdata[CMD_EN_BIT]) |=> (root_en_o && !root_off)); // R8
  AST_OFF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    root_off |-> (!root_on_i && !ext_en_i && !en_req_q)); // R9

endmodule

// File: tb/tb_clkroot_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_clkroot_cfg_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        root_on_i = 1'b0;
  logic        ext_en_i = 1'b0;
  logic        root_en_o;
  logic [2:0]  act_src_o;
  logic [1:0]  act_mode_o;
  logic [4:0]  act_prediv_o;
  logic [7:0]  act_m_o, act_n_o, act_d_o;

  always #2.5 clk = ~clk;

  clkroot_cfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .root_on_i(root_on_i),
    .ext_en_i(ext_en_i), .root_en_o(root_en_o), .act_src_o(act_src_o),
    .act_mode_o(act_mode_o), .act_prediv_o(act_prediv_o), .act_m_o(act_m_o),
    .act_n_o(act_n_o), .act_d_o(act_d_o)
  );

  localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_M = 5'h08, A_N = 5'h0C, A_D = 5'h10;
  localparam int K_RD = 0, K_ACT = 1, K_EN = 2;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  probe = 1'b0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  function automatic logic [63:0] cmdw(bit off, bit dd, bit dm, bit dn, bit dc, bit en, bit p);
    logic [31:0] w;
    w = '0;
    w[31] = off; w[7] = dd; w[6] = dm; w[5] = dn; w[4] = dc; w[1] = en; w[0] = p;
    return 64'(w);
  endfunction

  function automatic logic [63:0] actw(int src, int mode, int pre, int m, int n, int d);
    logic [33:0] v;
    v = {src[2:0], mode[1:0], pre[4:0], m[7:0], n[7:0], d[7:0]};
    return 64'(v);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [4:0] a, input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    bus_addr = a;
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pops the expected item and compares at the falling edge
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = 64'(bus_rdata);
        K_ACT:   act = 64'({act_src_o, act_mode_o, act_prediv_o, act_m_o, act_n_o, act_d_o});
        default: act = 64'(root_en_o);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,0), "R1 cmd after reset");
    chk(K_RD, A_CFG, 64'h0, "R1 cfg after reset");
    chk(K_ACT, A_CMD, actw(0,0,0,0,0,0), "R1 active after reset");

    // R6 equal-value write leaves flag clear
    wr(A_M, 32'h0);
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,0), "R6 equal write no dirty");

    // R10 + R2 config field placement, unused bits dropped
    wr(A_CFG, 32'hFFFF_E3E5);
    chk(K_RD, A_CFG, 64'h2305, "R10 cfg fields");
    chk(K_RD, A_CMD, cmdw(1,0,0,0,1,0,0), "R6 cfg dirty");
    chk(K_ACT, A_CMD, actw(0,0,0,0,0,0), "R2 active unchanged");

    wr(A_M, 32'hAB00_0003);
    wr(A_N, 32'h0000_00FA);
    wr(A_D, 32'h0000_00F7);
    chk(K_RD, A_M, 64'h03, "R2 M readback");
    chk(K_RD, A_N, 64'hFA, "R2 N readback");
    chk(K_RD, A_D, 64'hF7, "R2 D readback");
    chk(K_RD, A_CMD, cmdw(1,1,1,1,1,0,0), "R6 all dirty");

    // R3/R4 update window
    wr(A_CMD, 32'h1);
    chk(K_RD, A_CMD, cmdw(1,1,1,1,1,0,1), "R3 pending set");
    chk(K_ACT, A_CMD, actw(3,2,5,8'h03,8'hFA,8'hF7), "R3 active loaded");
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,1), "R7 dirty cleared, R4 still pending");
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,1), "R4 pending last cycle");
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,0), "R4 pending cleared");

    // R5 repeat request does not restart; zero write does not cancel
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h0);
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,1), "R5 still pending");
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,1), "R5 window end");
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,0), "R5 no extension");

    // R3 commit edge exactly one cycle after the command
    wr(A_CFG, 32'h0000_1107);
    wr(A_CMD, 32'h1);
    chk(K_ACT, A_CMD, actw(3,2,5,8'h03,8'hFA,8'hF7), "R3 old before commit");
    chk(K_ACT, A_CMD, actw(1,1,7,8'h03,8'hFA,8'hF7), "R3 new after commit");
    idle(4);

    // R7 write on commit edge differing from committed value
    wr(A_CFG, 32'h0000_0204);
    wr(A_N, 32'h0000_0010);
    wr(A_CMD, 32'h1);
    wr(A_CFG, 32'h0000_0004);
    chk(K_RD, A_CMD, cmdw(1,0,0,0,1,0,1), "R7 collision differing sets dirty");
    chk(K_RD, A_CFG, 64'h0004, "R7 shadow holds collision write");
    chk(K_ACT, A_CMD, actw(2,0,4,8'h03,8'h10,8'hF7), "R7 committed older shadow");
    idle(4);

    // R7 write on commit edge equal to committed value
    wr(A_CFG, 32'h0000_0300);
    wr(A_CMD, 32'h1);
    wr(A_CFG, 32'h0000_0300);
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,1), "R7 collision equal stays clean");
    idle(4);
    chk(K_ACT, A_CMD, actw(3,0,0,8'h03,8'h10,8'hF7), "R7 active after second commit");

    // R8/R9 enable and status
    wr(A_CMD, 32'h2);
    chk(K_RD, A_CMD, cmdw(0,0,0,0,0,1,0), "R8 request reads back, R9 on");
    chk(K_EN, A_CMD, 64'h1, "R8 root_en from request");
    wr(A_CMD, 32'h0);
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,0), "R9 off when idle");
    chk(K_EN, A_CMD, 64'h0, "R8 root_en dropped");
    ext_en_i = 1'b1;
    chk(K_RD, A_CMD, cmdw(0,0,0,0,0,0,0), "R9 external enable");
    chk(K_EN, A_CMD, 64'h1, "R8 root_en from external");
    ext_en_i = 1'b0; root_on_i = 1'b1;
    chk(K_RD, A_CMD, cmdw(0,0,0,0,0,0,0), "R9 datapath running");
    chk(K_EN, A_CMD, 64'h0, "R8 root_en not from datapath");
    root_on_i = 1'b0;
    wr(A_CMD, 32'h3);
    chk(K_RD, A_CMD, cmdw(0,0,0,0,0,1,1), "R8 enable with update");
    idle(5);
    wr(A_CMD, 32'h0);

    // R10 read-only bits, unmapped and misaligned addresses
    wr(A_CMD, 32'h8000_00F0);
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,0), "R10 status and dirty not writable");
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h09, 32'h0000_0055);
    chk(K_RD, A_M, 64'h03, "R10 stray writes leave M");
    chk(K_RD, 5'h14, 64'h0, "R10 unmapped reads zero");
    chk(K_RD, 5'h09, 64'h0, "R10 misaligned reads zero");
    chk(K_RD, A_CMD, cmdw(1,0,0,0,0,0,0), "R10 no dirty from stray writes");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule